// File: doc/BRIEF.md
# Cascaded One-Hot Population Counter

This block counts how many bits of an N-bit input word are set, without an adder tree. A chain of N identical steering stages carries a one-hot tally vector of N+1 lines. The chain is seeded with the "none counted" line high. At each stage one input bit chooses how the vector moves. A 0 bit leaves every line in its position. A 1 bit moves every line one position higher and drives the vacated lowest line to 0.

After the last stage exactly one line is high, and its index is the number of set input bits. A small encoder turns that line into a binary count. An optional register stage, chosen by parameter, captures both forms on the rising clock edge when the input is marked valid, and it raises a valid flag one cycle later. A synchronous reset clears the register stage. The block is used wherever a popcount is needed in one-hot form, for example to select one of N+1 actions by the number of active requesters. The binary form serves ordinary arithmetic use.

Top module: `ones_tally`

## Requirements
- R1: Every valid result on `onehot_out` has exactly one of its N+1 lines high. Line k (bit position k) means "k input bits set".
- R2: An all-zero input word gives line 0 high and `count_out` = 0. This is the seed, which no stage moves.
- R3: A 0 input bit leaves the tally unchanged. Clearing any single set bit of a word lowers the asserted line by exactly one position.
- R4: A 1 input bit moves the tally up by exactly one position. A word with a single set bit gives line 1, whatever the bit position.
- R5: An all-ones word gives line N, the highest line. No word with fewer set bits asserts line N.
- R6: `count_out` is the binary index of the asserted `onehot_out` line. It equals the number of set bits in the captured word.
- R7: With only input bits 0 and 1 in use, the patterns 00, 01, 10 and 11 give lines 0, 1, 1 and 2.
- R8: With the register stage on, the result for a word presented with `in_valid` = 1 appears on the outputs after the next rising edge, and `out_valid` is 1 for exactly that cycle.
- R9: A synchronous reset (`rst` = 1 at a rising edge) drives `out_valid`, `onehot_out` and `count_out` to 0.
- R10: While `in_valid` = 0, the register stage holds its last result: `onehot_out` and `count_out` do not change and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stage |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `data_in` as a word to count |
| data_in | input | N | Input word whose set bits are counted |
| onehot_out | output | N+1 | One-hot tally, line k means k bits set |
| count_out | output | $clog2(N+1) | Binary form of the tally |
| out_valid | output | 1 | Result on the outputs is fresh this cycle |

## Verification
A stage that steers wrongly shows up as a tally line off by one position, or as zero or two lines high. Either appears at the outputs in the cycle after the offending word is captured. Walking a single set bit through every input position exposes a stage at that position that does not move the tally. An all-ones word drives the tally through every stage to the top line. Comparing `count_out` with the asserted line shows an encoder fault in that same cycle. A register that fails to hold its value shows up in the first idle cycle after a result.

// File: rtl/ones_tally_pkg.sv
package ones_tally_pkg;
    function automatic int tally_cnt_w(input int n_bits);
        return (n_bits < 1) ? 1 : $clog2(n_bits + 1);
    endfunction
endpackage

// File: rtl/tally_step.sv
// One steering stage: hold position on a 0 bit, move up one on a 1 bit.
module tally_step #(
    parameter int LINES = 9
) (
    input  logic [LINES-1:0] vec_in,
    input  logic             bit_in,
    output logic [LINES-1:0] vec_out
);
    always_comb begin
        if (bit_in) begin
            vec_out = vec_in << 1;   // lowest line driven to 0
        end else begin
            vec_out = vec_in;
        end
    end
endmodule

// File: rtl/tally_chain.sv
module tally_chain #(
    parameter int N = 8,
    localparam int LINES = N + 1
) (
    input  logic [N-1:0]           bits_in,
    output logic [LINES*LINES-1:0] stage_bus,
    output logic [LINES-1:0]       tally_out
);
    // stage_bus slice k is the tally before stage k; slice N is the result
    assign stage_bus[0 +: LINES] = {{(LINES-1){1'b0}}, 1'b1};

    for (genvar k = 0; k < N; k++) begin : g_step
        tally_step #(.LINES(LINES)) step_i (
            .vec_in  (stage_bus[k*LINES +: LINES]),
            .bit_in  (bits_in[k]),
            .vec_out (stage_bus[(k+1)*LINES +: LINES])
        );
    end

    assign tally_out = stage_bus[N*LINES +: LINES];
endmodule

// File: rtl/tally_encode.sv
module tally_encode #(
    parameter int LINES = 9,
    parameter int CW = 4
) (
    input  logic [LINES-1:0] onehot_in,
    output logic [CW-1:0]    index_out
);
    always_comb begin
        index_out = '0;
        for (int i = 0; i < LINES; i++) begin
            if (onehot_in[i]) begin
                index_out = index_out | CW'(i);
            end
        end
    end
endmodule

// File: rtl/ones_tally.sv
module ones_tally
    import ones_tally_pkg::*;
#(
    parameter int N = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int LINES = N + 1,
    localparam int CW = tally_cnt_w(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [N-1:0]     data_in,
    output logic [LINES-1:0] onehot_out,
    output logic [CW-1:0]    count_out,
    output logic             out_valid
);
    logic [LINES*LINES-1:0] stage_bus;
    logic [LINES-1:0]       tally_comb;
    logic [CW-1:0]          count_comb;

    tally_chain #(.N(N)) chain_i (
        .bits_in   (data_in),
        .stage_bus (stage_bus),
        .tally_out (tally_comb)
    );

    tally_encode #(.LINES(LINES), .CW(CW)) enc_i (
        .onehot_in (tally_comb),
        .index_out (count_comb)
    );

    if (REG_OUT) begin : g_reg
        logic [LINES-1:0] oh_q;
        logic [CW-1:0]    cnt_q;
        logic             vld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                oh_q  <= '0;
                cnt_q <= '0;
                vld_q <= 1'b0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) begin
                    oh_q  <= tally_comb;
                    cnt_q <= count_comb;
                end
            end
        end

        assign onehot_out = oh_q;
        assign count_out  = cnt_q;
        assign out_valid  = vld_q;
    end else begin : g_comb
        assign onehot_out = tally_comb;
        assign count_out  = count_comb;
        assign out_valid  = in_valid;
    end
endmodule

// File: rtl/ones_tally_chk.sv
module ones_tally_chk #(
    parameter int N = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int LINES = N + 1,
    localparam int CW = ones_tally_pkg::tally_cnt_w(N)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [N-1:0]           data_in,
    input logic [LINES-1:0]       onehot_out,
    input logic [CW-1:0]          count_out,
    input logic                   out_valid,
    input logic [LINES*LINES-1:0] stage_bus
);
    // R1: every stage of the chain carries exactly one high line
    for (genvar k = 0; k <= N; k++) begin : g_stage
        a_r1_stage_onehot: assert property (@(posedge clk) disable iff (rst)
            $countones(stage_bus[k*LINES +: LINES]) == 1);
    end

    a_r1_out_onehot: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(onehot_out) == 1);

    a_r6_index_match: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> onehot_out[count_out]);

    a_r5_top_line: assert property (@(posedge clk) disable iff (rst)
        (out_valid && onehot_out[N]) |-> count_out == CW'(N));

    if (REG_OUT) begin : g_reg_chk
        a_r8_popcount: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> count_out == CW'($countones($past(data_in))));

        a_r10_hold: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ($stable(onehot_out) && !out_valid));

        a_r9_reset_clear: assert property (@(posedge clk)
            $past(rst) |-> (!out_valid && onehot_out == '0));
    end
endmodule

bind ones_tally ones_tally_chk #(.N(N), .REG_OUT(REG_OUT)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .data_in    (data_in),
    .onehot_out (onehot_out),
    .count_out  (count_out),
    .out_valid  (out_valid),
    .stage_bus  (stage_bus)
);

// File: tb/ones_tally_tb_top.sv
module ones_tally_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int LINES = N + 1;
    localparam int CW = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [N-1:0]     data_in = '0;
    logic [LINES-1:0] onehot_out;
    logic [CW-1:0]    count_out;
    logic             out_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    ones_tally #(.N(N), .REG_OUT(1'b1)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .data_in    (data_in),
        .onehot_out (onehot_out),
        .count_out  (count_out),
        .out_valid  (out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int pop(input logic [N-1:0] w);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(w[i]);
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one word for one cycle; return at the negedge after capture.
    task automatic present(input logic [N-1:0] w);
        @(negedge clk);
        data_in  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_word(input string req, input logic [N-1:0] w);
        int c;
        present(w);
        c = pop(w);
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " onehot"}, 32'(onehot_out), 32'(LINES'(1) << c));
        check({req, " count"}, 32'(count_out), 32'(c));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 reset valid", 32'(out_valid), 32'd0);
        check("R9 reset onehot", 32'(onehot_out), 32'd0);
        check("R9 reset count", 32'(count_out), 32'd0);
    endtask

    task automatic t_zero();
        check_word("R2 zero word", '0);
    endtask

    task automatic t_walk();
        for (int i = 0; i < N; i++) check_word("R4 single bit", N'(1) << i);
    endtask

    task automatic t_clear_bit();
        logic [N-1:0] w = 8'b1011_0110;
        check_word("R3 base word", w);
        for (int i = 0; i < N; i++) begin
            if (w[i]) check_word("R3 one bit cleared", w & ~(N'(1) << i));
        end
    endtask

    task automatic t_all_ones();
        check_word("R5 all ones", '1);
        check_word("R5 seven set", 8'b1111_1110);
        check("R5 top line clear", 32'(onehot_out[N]), 32'd0);
    endtask

    task automatic t_two_input();
        for (int p = 0; p < 4; p++) check_word("R7 two input", N'(p));
    endtask

    task automatic t_patterns();
        check_word("R6 pattern a", 8'hA5);
        check_word("R6 pattern b", 8'h3C);
        check_word("R6 pattern c", 8'h81);
        check_word("R1 pattern d", 8'h7F);
    endtask

    task automatic t_timing_hold();
        logic [LINES-1:0] oh;
        @(negedge clk);
        data_in = 8'h0F;
        in_valid = 1'b1;
        check("R8 not yet updated", 32'(out_valid), 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        data_in = 8'hFF;
        check("R8 result after one edge", 32'(count_out), 32'd4);
        check("R8 valid pulse", 32'(out_valid), 32'd1);
        oh = onehot_out;
        @(negedge clk);
        check("R10 valid low idle", 32'(out_valid), 32'd0);
        check("R10 onehot held", 32'(onehot_out), 32'(oh));
        check("R10 count held", 32'(count_out), 32'd4);
    endtask

    task automatic t_reset_mid();
        check_word("R9 before reset", 8'h33);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 mid reset valid", 32'(out_valid), 32'd0);
        check("R9 mid reset onehot", 32'(onehot_out), 32'd0);
        check("R9 mid reset count", 32'(count_out), 32'd0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_zero();
        t_walk();
        t_clear_bit();
        t_all_ones();
        t_two_input();
        t_patterns();
        t_timing_hold();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule